// File: doc/BRIEF.md
# Access Permission Checker with Fault Status

This block judges every finished address translation against the 3-bit access code held in the page entry. Each request carries the kind of access (read, write or execute), the privilege mode (user or supervisor) and the access code. One cycle later the block answers with a response strobe and an allow flag. When the access is refused it also raises a single-cycle trap pulse.

Besides the permission check, the block keeps a fault status register that software reads through a simple select/write port. Faults reach the register from three sources: refused checks, an external fault report (invalid address, translation error or bus error with a bus-error kind), and an internal-error strobe. Only the most important pending fault is held. A read returns the register and empties it. A write does nothing.

Top module: `acc_guard`

## Requirements
- R1: Access kind encoding is 0 read, 1 write, 2 execute, 3 reserved (always refused). Access codes 0 to 4 grant the same rights in both modes: 0 read, 1 read+write, 2 read+execute, 3 read+write+execute, 4 execute only.
- R2: Access code 5 grants read only in user mode and read+write in supervisor mode.
- R3: Access codes 6 and 7 grant nothing in user mode. In supervisor mode, code 6 grants read+execute and code 7 grants read+write+execute.
- R4: A request accepted on a clock edge gives rsp_valid high for exactly the next cycle, with rsp_allow showing the decision. trap is high in that same cycle only when the access is refused, and it is never high without rsp_valid.
- R5: A refused user-mode access with code 6 or 7 records fault type 3 (privilege violation). Any other refused access records fault type 2 (protection error).
- R6: The fault type field is reg_rdata[2:0], with codes 0 none, 1 invalid address, 2 protection, 3 privilege, 4 translation, 5 bus error, 6 internal. Priority from highest to lowest is 6, 4, 5, 3, 2, 1. When several faults arrive in one cycle, the highest-priority one is taken.
- R7: A new fault of equal or lower priority leaves the recorded fault unchanged. A fault of higher priority replaces it.
- R8: When a bus-error fault is recorded as the fault type, its bus-error kind is stored in reg_rdata[4:3]. The int_err strobe sets the sticky flag reg_rdata[5] and also reports fault type 6.
- R9: A read (reg_sel high, reg_wr low) shows the register on reg_rdata in the same cycle and clears it on that clock edge. reg_rdata is zero when there is no read.
- R10: A write (reg_sel and reg_wr high) leaves the register unchanged.
- R11: A fault that arrives in the same cycle as a read is recorded into the freshly cleared register and is not lost.
- R12: After reset, rsp_valid and trap are low and the register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Check request strobe |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| chk_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| chk_code | input | 3 | Access code from the page entry |
| rsp_valid | output | 1 | Check response strobe |
| rsp_allow | output | 1 | Access permitted |
| trap | output | 1 | Single-cycle trap on a refused access |
| ext_flt_valid | input | 1 | External fault report strobe |
| ext_flt_type | input | 3 | Fault type of the external report |
| ext_bus_kind | input | BK_W | Bus-error kind sent with a bus-error report |
| int_err | input | 1 | Internal inconsistency strobe |
| reg_sel | input | 1 | Status register access strobe |
| reg_wr | input | 1 | 1 = write (ignored), 0 = read |
| reg_rdata | output | REG_W | Status register read data |

## Verification
A read that clears the status register can fall in the same cycle as a new fault, which may come from a refused check, an external report or the internal strobe. The bench provokes this by raising a read and an external invalid-address report on the same edge while a translation fault is held. It expects the read data to show the old translation fault and a second read to show only the invalid-address fault. Simultaneous fault sources are also merged: a refused supervisor-only access and a lower-priority external report arrive together, and only the privilege violation must remain.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FT_NONE     = 3'd0,
        FT_INVALID  = 3'd1,
        FT_PROTECT  = 3'd2,
        FT_PRIV     = 3'd3,
        FT_XLATE    = 3'd4,
        FT_BUS      = 3'd5,
        FT_INTERNAL = 3'd6,
        FT_RSVD     = 3'd7
    } fault_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef struct packed {
        logic valid;
        logic allow;
        logic trap;
    } rsp_t;

    localparam int FT_W   = 3;
    localparam int N_SRC  = 3;

    // Rights granted by an access code in a given mode.
    function automatic rights_t rights_of(input logic [2:0] code, input logic sup);
        rights_t g;
        unique case (code)
            3'd0: g = '{x: 1'b0, w: 1'b0, r: 1'b1};
            3'd1: g = '{x: 1'b0, w: 1'b1, r: 1'b1};
            3'd2: g = '{x: 1'b1, w: 1'b0, r: 1'b1};
            3'd3: g = '{x: 1'b1, w: 1'b1, r: 1'b1};
            3'd4: g = '{x: 1'b1, w: 1'b0, r: 1'b0};
            3'd5: g = '{x: 1'b0, w: sup,  r: 1'b1};
            3'd6: g = '{x: sup,  w: 1'b0, r: sup};
            default: g = '{x: sup, w: sup, r: sup};
        endcase
        return g;
    endfunction

    // Priority rank of a fault type; larger wins.
    function automatic logic [2:0] rank_of(input fault_e f);
        logic [2:0] rk;
        unique case (f)
            FT_INTERNAL: rk = 3'd6;
            FT_XLATE:    rk = 3'd5;
            FT_BUS:      rk = 3'd4;
            FT_PRIV:     rk = 3'd3;
            FT_PROTECT:  rk = 3'd2;
            FT_INVALID:  rk = 3'd1;
            default:     rk = 3'd0;
        endcase
        return rk;
    endfunction

endpackage

// File: rtl/acc_perm_decode.sv
module acc_perm_decode
    import acc_guard_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       sup,
    input  logic [2:0] code,
    output logic       allow,
    output fault_e     deny_ft
);
    rights_t   grant;
    acc_kind_e k;

    always_comb begin
        grant = rights_of(code, sup);
        k     = acc_kind_e'(kind);
        unique case (k)
            ACC_READ:  allow = grant.r;
            ACC_WRITE: allow = grant.w;
            ACC_EXEC:  allow = grant.x;
            default:   allow = 1'b0;
        endcase
        if (allow)
            deny_ft = FT_NONE;
        else if (!sup && (code[2:1] == 2'b11))
            deny_ft = FT_PRIV;
        else
            deny_ft = FT_PROTECT;
    end
endmodule

// File: rtl/acc_fault_pick.sv
module acc_fault_pick
    import acc_guard_pkg::*;
#(
    parameter int NS = 3
) (
    input  fault_e src [NS],
    output fault_e win
);
    always_comb begin
        win = FT_NONE;
        for (int i = 0; i < NS; i++) begin
            if (rank_of(src[i]) > rank_of(win))
                win = src[i];
        end
    end
endmodule

// File: rtl/acc_fault_status.sv
module acc_fault_status
    import acc_guard_pkg::*;
#(
    parameter int BK_W  = 2,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  fault_e           new_ft,
    input  logic [BK_W-1:0]  new_bk,
    input  logic             ie_set,
    output fault_e           ft_q,
    output logic [REG_W-1:0] word
);
    localparam int BK_LSB = FT_W;
    localparam int IE_BIT = FT_W + BK_W;

    logic [BK_W-1:0] bk_q, bk_d, bk_base;
    logic            ie_q, ie_d, ie_base;
    fault_e          ft_d, ft_base;

    always_comb begin
        ft_base = rd ? FT_NONE : ft_q;
        bk_base = rd ? '0 : bk_q;
        ie_base = rd ? 1'b0 : ie_q;
        ft_d    = ft_base;
        bk_d    = bk_base;
        if (rank_of(new_ft) > rank_of(ft_base)) begin
            ft_d = new_ft;
            if (new_ft == FT_BUS)
                bk_d = new_bk;
        end
        ie_d = ie_base | ie_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ft_q <= FT_NONE;
            bk_q <= '0;
            ie_q <= 1'b0;
        end else begin
            ft_q <= ft_d;
            bk_q <= bk_d;
            ie_q <= ie_d;
        end
    end

    always_comb begin
        word                     = '0;
        word[FT_W-1:0]           = ft_q;
        word[BK_LSB +: BK_W]     = bk_q;
        word[IE_BIT]             = ie_q;
    end
endmodule

// File: rtl/acc_guard.sv
module acc_guard
    import acc_guard_pkg::*;
#(
    parameter int BK_W  = 2,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_valid,
    input  logic [1:0]       chk_kind,
    input  logic             chk_super,
    input  logic [2:0]       chk_code,
    output logic             rsp_valid,
    output logic             rsp_allow,
    output logic             trap,
    input  logic             ext_flt_valid,
    input  logic [2:0]       ext_flt_type,
    input  logic [BK_W-1:0]  ext_bus_kind,
    input  logic             int_err,
    input  logic             reg_sel,
    input  logic             reg_wr,
    output logic [REG_W-1:0] reg_rdata
);
    logic       dec_allow;
    fault_e     dec_ft;
    fault_e     cand [N_SRC];
    fault_e     win_ft;
    fault_e     fs_ft;
    logic [REG_W-1:0] fs_word;
    logic       rd_now;
    rsp_t       rsp_q;

    acc_perm_decode u_dec (
        .kind    (chk_kind),
        .sup     (chk_super),
        .code    (chk_code),
        .allow   (dec_allow),
        .deny_ft (dec_ft)
    );

    always_comb begin
        cand[0] = chk_valid     ? dec_ft                 : FT_NONE;
        cand[1] = ext_flt_valid ? fault_e'(ext_flt_type) : FT_NONE;
        cand[2] = int_err       ? FT_INTERNAL            : FT_NONE;
    end

    acc_fault_pick #(.NS(N_SRC)) u_pick (
        .src (cand),
        .win (win_ft)
    );

    assign rd_now = reg_sel && !reg_wr;

    acc_fault_status #(.BK_W(BK_W), .REG_W(REG_W)) u_fs (
        .clk    (clk),
        .rst    (rst),
        .rd     (rd_now),
        .new_ft (win_ft),
        .new_bk (ext_bus_kind),
        .ie_set (int_err),
        .ft_q   (fs_ft),
        .word   (fs_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= chk_valid;
            rsp_q.allow <= chk_valid && dec_allow;
            rsp_q.trap  <= chk_valid && !dec_allow;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;
    assign trap      = rsp_q.trap;
    assign reg_rdata = rd_now ? fs_word : '0;
endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk
    import acc_guard_pkg::*;
#(
    parameter int BK_W  = 2,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             chk_valid,
    input logic             chk_super,
    input logic [2:0]       chk_code,
    input logic             rsp_valid,
    input logic             rsp_allow,
    input logic             trap,
    input logic             ext_flt_valid,
    input logic [2:0]       ext_flt_type,
    input logic             int_err,
    input logic             reg_sel,
    input logic             reg_wr,
    input fault_e           fs_ft,
    input logic [REG_W-1:0] fs_word
);
    localparam int IE_BIT = FT_W + BK_W;

    logic rd_now;
    assign rd_now = reg_sel && !reg_wr;

    a_r4_trap_needs_rsp: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rsp_valid && !rsp_allow));

    a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);

    a_r4_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> (!rsp_valid && !trap));

    a_r3_user_top_codes_trap: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !chk_super && (chk_code[2:1] == 2'b11)) |=> trap);

    a_r7_no_downgrade: assert property (@(posedge clk) disable iff (rst)
        !rd_now |=> (rank_of(fs_ft) >= rank_of($past(fs_ft))));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_now && !chk_valid && !ext_flt_valid && !int_err) |=> (fs_word == '0));

    a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && !chk_valid && !ext_flt_valid && !int_err) |=> $stable(fs_word));

    a_r8_internal_flag: assert property (@(posedge clk) disable iff (rst)
        int_err |=> (fs_word[IE_BIT] && (fs_ft == FT_INTERNAL)));

    a_r11_read_keeps_new: assert property (@(posedge clk) disable iff (rst)
        (rd_now && ext_flt_valid && (ext_flt_type == 3'd1) && !chk_valid && !int_err)
            |=> (fs_ft == FT_INVALID));
endmodule

bind acc_guard acc_guard_chk #(.BK_W(BK_W), .REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .chk_valid     (chk_valid),
    .chk_super     (chk_super),
    .chk_code      (chk_code),
    .rsp_valid     (rsp_valid),
    .rsp_allow     (rsp_allow),
    .trap          (trap),
    .ext_flt_valid (ext_flt_valid),
    .ext_flt_type  (ext_flt_type),
    .int_err       (int_err),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .fs_ft         (fs_ft),
    .fs_word       (fs_word)
);

// File: tb/acc_guard_bench.sv
`timescale 1ns/1ps
module acc_guard_bench;
    localparam int BK_W  = 2;
    localparam int REG_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             chk_valid = 1'b0;
    logic [1:0]       chk_kind = '0;
    logic             chk_super = 1'b0;
    logic [2:0]       chk_code = '0;
    logic             rsp_valid, rsp_allow, trap;
    logic             ext_flt_valid = 1'b0;
    logic [2:0]       ext_flt_type = '0;
    logic [BK_W-1:0]  ext_bus_kind = '0;
    logic             int_err = 1'b0;
    logic             reg_sel = 1'b0;
    logic             reg_wr = 1'b0;
    logic [REG_W-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_guard #(.BK_W(BK_W), .REG_W(REG_W)) u_acc_guard (
        .clk(clk), .rst(rst),
        .chk_valid(chk_valid), .chk_kind(chk_kind), .chk_super(chk_super), .chk_code(chk_code),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .trap(trap),
        .ext_flt_valid(ext_flt_valid), .ext_flt_type(ext_flt_type), .ext_bus_kind(ext_bus_kind),
        .int_err(int_err), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    // Rights from R1..R3: returns 1 when the access is permitted.
    function automatic bit ref_allow(input int k, input bit s, input int c);
        bit r, w, x;
        case (c)
            0: begin r = 1; w = 0; x = 0; end
            1: begin r = 1; w = 1; x = 0; end
            2: begin r = 1; w = 0; x = 1; end
            3: begin r = 1; w = 1; x = 1; end
            4: begin r = 0; w = 0; x = 1; end
            5: begin r = 1; w = s; x = 0; end
            6: begin r = s; w = 0; x = s; end
            default: begin r = s; w = s; x = s; end
        endcase
        if (k == 0) return r;
        if (k == 1) return w;
        if (k == 2) return x;
        return 1'b0;
    endfunction

    function automatic logic [REG_W-1:0] mk_word(input int ft, input int bk, input bit ie);
        logic [REG_W-1:0] v;
        v = '0;
        v[2:0] = ft[2:0];
        v[4:3] = bk[1:0];
        v[5] = ie;
        return v;
    endfunction

    task automatic expect_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_check(input int k, input bit s, input int c, input string req);
        bit a;
        a = ref_allow(k, s, c);
        @(negedge clk);
        chk_valid = 1'b1; chk_kind = k[1:0]; chk_super = s; chk_code = c[2:0];
        @(posedge clk); #1;
        expect_val(req, {rsp_valid, rsp_allow, trap}, {1'b1, a, ~a});
        @(negedge clk);
        chk_valid = 1'b0;
        @(posedge clk); #1;
        expect_val("R4 trap pulse ends", {rsp_valid, trap}, 0);
    endtask

    task automatic read_expect(input logic [REG_W-1:0] exp, input string req);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0;
        #1;
        expect_val(req, reg_rdata, exp);
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic ext_fault(input int ft, input int bk);
        @(negedge clk);
        ext_flt_valid = 1'b1; ext_flt_type = ft[2:0]; ext_bus_kind = bk[BK_W-1:0];
        @(negedge clk);
        ext_flt_valid = 1'b0;
    endtask

    task automatic t_reset;
        expect_val("R12 reset rsp/trap", {rsp_valid, trap}, 0);
        expect_val("R9 no-read data zero", reg_rdata, 0);
        read_expect('0, "R12 reset register");
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 4; k++)
                    do_check(k, s[0], c, c < 5 ? (c == 5 ? "R2" : "R1 rights") :
                                          (c == 5 ? "R2 code5" : "R3 code6/7"));
        read_expect(mk_word(3, 0, 0), "R6 sweep keeps privilege");
    endtask

    task automatic t_classes;
        do_check(0, 1'b0, 6, "R3 user code6");
        read_expect(mk_word(3, 0, 0), "R5 privilege class");
        do_check(1, 1'b1, 0, "R1 super write code0");
        read_expect(mk_word(2, 0, 0), "R5 protection class");
        do_check(1, 1'b0, 5, "R2 user write code5");
        read_expect(mk_word(2, 0, 0), "R5 code5 protection");
    endtask

    task automatic t_priority;
        do_check(2, 1'b0, 0, "R1 exec code0");
        ext_fault(1, 0);
        read_expect(mk_word(2, 0, 0), "R7 lower kept out");
        do_check(2, 1'b0, 0, "R1 exec code0");
        ext_fault(5, 2);
        do_check(0, 1'b0, 7, "R3 user code7");
        read_expect(mk_word(5, 2, 0), "R8 bus kind recorded");
        ext_fault(5, 1);
        ext_fault(5, 3);
        ext_fault(4, 0);
        @(negedge clk); int_err = 1'b1;
        @(negedge clk); int_err = 1'b0;
        read_expect(mk_word(6, 1, 1), "R7 R8 internal over translation");
    endtask

    task automatic t_write;
        do_check(0, 1'b0, 4, "R1 read code4");
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        read_expect(mk_word(2, 0, 0), "R10 write ignored");
    endtask

    task automatic t_concurrent;
        ext_fault(4, 0);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0;
        ext_flt_valid = 1'b1; ext_flt_type = 3'd1;
        #1;
        expect_val("R11 old value read", reg_rdata, mk_word(4, 0, 0));
        @(negedge clk);
        reg_sel = 1'b0; ext_flt_valid = 1'b0;
        read_expect(mk_word(1, 0, 0), "R11 new fault kept");
        @(negedge clk);
        chk_valid = 1'b1; chk_kind = 2'd0; chk_super = 1'b0; chk_code = 3'd7;
        ext_flt_valid = 1'b1; ext_flt_type = 3'd1;
        @(negedge clk);
        chk_valid = 1'b0; ext_flt_valid = 1'b0;
        read_expect(mk_word(3, 0, 0), "R6 same-cycle merge");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset;
        t_sweep;
        t_classes;
        t_priority;
        t_write;
        t_concurrent;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule